// File: doc/BRIEF.md
# Audio Serial Playback Controller

This block is the transmit half of a stereo audio serial port. Software, or a DMA engine, writes samples into a 32-entry transmit queue through a word-addressed 32-bit register window. A serializer drains the queue one sample per channel slot and shifts each sample out MSB first on a serial data line. The data line is framed by a bit clock and a word-select (frame) clock. Each frame holds 64 bit periods, split into a left slot and a right slot of 32 bits each.

The bit clock and the frame clock are chosen separately. Each is either produced locally from a programmable divider or taken from an external source through a two-flop synchronizer. The serializer supports two framings:
- standard I2S, where the MSB comes one bit after the word-select edge;
- MSB-justified, where the MSB comes on the edge itself.

Samples can be 8, 16, 20 or 24 bits wide. A mono mode sends each queued word on both channels.

When the queue holds too few words, a DMA request is raised. A sticky underrun flag records any slot that found the queue empty. On an underrun the slot is filled with zeros or with the last sample sent. The system clock `clk` stands for twice the audio master clock, so one frame lasts 128·N clock cycles.

Top module: `aud_tx_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 config, 0x04 control, 0x10 format, 0x14 queue status, 0x1C port status, 0x30 divider and 0x34 data. Reads return the value one cycle after the request. Unused bits read 0, and every register resets to 0.
  - Config fields: bit 0 enable, bit 1 frame-clock master, bit 2 bit-clock master, bit 6 repeat-last, bits 11:8 threshold T.
  - Control fields: bits 21:19 size code, bit 14 DMA enable, bit 11 mono, bit 1 play.
  - Format: bit 0 selects MSB-justified framing.
  - Divider: bits 3:0 hold D.
- R2: Each write to 0x34 pushes bits 23:0 into a 32-entry queue. A push to a full queue is dropped. The queue occupancy reads in bits 5:0 of 0x14.
- R3: Writing 1 to control bit 8 (flush) or to config bit 3 (soft reset) empties the queue. Both bits always read 0.
- R4: The DMA request output is high when all of these hold: enable, play and DMA enable are set, and the occupancy is at most 2·T. It lags the register state by one cycle.
- R5: When the port is master, the bit clock has a half period of D+1 clock cycles. A frame lasts 64 bit periods, with word select low during the left slot.
- R6: Data changes on the falling bit-clock edge and goes out MSB first, followed by zeros to the end of the 32-bit slot. In I2S framing (format bit 0 = 0) the MSB follows the word-select edge by one bit period. In MSB-justified framing it is sent on that edge.
- R7: The size code sets the sample width: 0 is 8 bits, 1 is 16 bits, 3 is 20 bits and 4 is 24 bits. The reserved codes 2, 5, 6 and 7 act as 16 bits. A sample occupies the low bits of a queued word.
- R8: With mono set, one word is popped per frame and sent in both slots.
- R9: A slot that finds the queue empty sets the sticky underrun flag, bit 8 of 0x14. Writing 1 to that bit clears the flag. The slot sends zeros, or the last sample sent when repeat-last is set.
- R10: A clock whose master bit is clear is driven low at the output, and the serializer follows the external input instead. The slot position restarts whenever the external word select changes.
- R11: Bit 2 of 0x1C reads 1 once the serializer has shifted a bit while running. It reads 0 while the port is stopped.
- R12: While enable or play is clear, serial data is 0, nothing is popped, and the clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 1 | Register access request |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 6 | Byte offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after a read |
| ext_bclk | input | 1 | External bit clock |
| ext_ws | input | 1 | External word select |
| bclk_out | output | 1 | Bit clock when master, else 0 |
| ws_out | output | 1 | Word select when master, else 0 |
| sdata_out | output | 1 | Serial data |
| dma_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its default parameters: a 32-entry queue, a 4-bit divider and a 4-bit threshold. With these values the full-queue drop and a threshold of 2·T are both reached with a few dozen writes. The divider is set to D=1 in every test. That gives a 256-cycle frame, so a full two-frame decode of the master-mode serial stream stays short. In the slave test the bench drives the external clocks slowly enough for the synchronizer delay to settle inside each half bit.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int AW       = 6;

  localparam logic [AW-1:0] OFS_CFG  = 6'h00;
  localparam logic [AW-1:0] OFS_CTL  = 6'h04;
  localparam logic [AW-1:0] OFS_FMT  = 6'h10;
  localparam logic [AW-1:0] OFS_QST  = 6'h14;
  localparam logic [AW-1:0] OFS_PST  = 6'h1C;
  localparam logic [AW-1:0] OFS_DIV  = 6'h30;
  localparam logic [AW-1:0] OFS_DATA = 6'h34;

  function automatic logic [4:0] size_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd8;
      3'd3:    return 5'd20;
      3'd4:    return 5'd24;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 24,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic [LW-1:0]    level
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic             do_push, do_pop;

  assign do_push = push && (level != FULL_LVL);
  assign do_pop  = pop && (level != '0);
  assign empty   = (level == '0);
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0)); // R3
endmodule

// File: rtl/aud_tx_bitclk.sv
module aud_tx_bitclk #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_bclk,
  output logic             bclk,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             s1, s2, s3;
  logic             tick;

  assign tick     = (cnt == div);
  assign fall_evt = run && (master ? (tick && bclk) : (s3 && !s2));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      bclk <= 1'b1;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= ext_bclk; s2 <= s1; s3 <= s2;
    end
  end

  AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && master && $past(run) && !$past(tick)) |-> $stable(bclk)); // R5
endmodule

// File: rtl/aud_tx_serial.sv
module aud_tx_serial
  import aud_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                run,
  input  logic                fall_evt,
  input  logic                frame_master,
  input  logic                ext_ws,
  input  logic                msb_just,
  input  logic [2:0]          size_code,
  input  logic                mono,
  input  logic                repeat_last,
  input  logic                q_empty,
  input  logic [SAMPLE_W-1:0] q_head,
  output logic                pop,
  output logic                underrun_set,
  output logic                sdata,
  output logic                ws,
  output logic                busy
);
  logic [5:0]          pos, npos;
  logic                w1, w2;
  logic                load, need_pop;
  logic [SAMPLE_W-1:0] cur, new_samp, samp_sel;
  logic [4:0]          nbits, k, idx;
  logic                sbit;

  always_comb begin
    if (!frame_master && (w2 != pos[5])) npos = {w2, 5'd0};
    else                                 npos = pos + 6'd1;
  end

  assign load         = run && fall_evt && (npos[4:0] == 5'd0);
  assign need_pop     = load && (!npos[5] || !mono);
  assign pop          = need_pop && !q_empty;
  assign underrun_set = need_pop && q_empty;

  always_comb begin
    if (mono && npos[5])  new_samp = cur;
    else if (!q_empty)    new_samp = q_head;
    else if (repeat_last) new_samp = cur;
    else                  new_samp = '0;
  end

  assign samp_sel = load ? new_samp : cur;
  assign nbits    = size_bits(size_code);
  assign k        = msb_just ? npos[4:0] : (npos[4:0] - 5'd1);
  assign idx      = nbits - 5'd1 - k;
  assign sbit     = (k < nbits) ? samp_sel[idx] : 1'b0;
  assign ws       = pos[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      w1 <= 1'b1; w2 <= 1'b1;
    end else begin
      w1 <= ext_ws; w2 <= w1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      pos   <= '1;
      cur   <= '0;
      sdata <= 1'b0;
      busy  <= 1'b0;
    end else if (fall_evt) begin
      pos   <= npos;
      sdata <= sbit;
      busy  <= 1'b1;
      if (load) cur <= new_samp;
    end
  end

  AST_POP_WHEN_RUN: assert property (@(posedge clk) disable iff (rst)
    pop |-> run); // R12
  AST_SDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sdata); // R12
  AST_MONO_ONE_POP: assert property (@(posedge clk) disable iff (rst)
    (mono && load && npos[5]) |-> !pop); // R8
endmodule

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int DIV_W      = 4,
  parameter int THR_W      = 4,
  localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_sel,
  input  logic        csr_we,
  input  logic [5:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        ext_bclk,
  input  logic        ext_ws,
  output logic        bclk_out,
  output logic        ws_out,
  output logic        sdata_out,
  output logic        dma_req
);
  logic             cfg_en, cfg_fm, cfg_bm, cfg_rpt;
  logic [THR_W-1:0] cfg_thr;
  logic [2:0]       ctl_size;
  logic             ctl_dma, ctl_mono, ctl_play;
  logic             fmt_msbj;
  logic [DIV_W-1:0] div_q;
  logic             underrun_q;

  logic             wr, rd, soft_rst, flush, push, run;
  logic             q_pop, q_empty, urun_set, busy, ser_ws, bclk_int, fall_evt;
  logic [SAMPLE_W-1:0] q_head;
  logic [LW-1:0]    level;
  logic [31:0]      rd_mux;

  assign wr       = csr_sel && csr_we;
  assign rd       = csr_sel && !csr_we;
  assign soft_rst = wr && (csr_addr == OFS_CFG) && csr_wdata[3];
  assign flush    = wr && (csr_addr == OFS_CTL) && csr_wdata[8];
  assign push     = wr && (csr_addr == OFS_DATA);
  assign run      = cfg_en && ctl_play;

  always_ff @(posedge clk) begin
    if (rst) begin
      {cfg_en, cfg_fm, cfg_bm, cfg_rpt} <= '0;
      cfg_thr  <= '0;
      ctl_size <= '0;
      {ctl_dma, ctl_mono, ctl_play} <= '0;
      fmt_msbj <= 1'b0;
      div_q    <= '0;
    end else if (wr) begin
      case (csr_addr)
        OFS_CFG: begin
          cfg_en  <= csr_wdata[0];
          cfg_fm  <= csr_wdata[1];
          cfg_bm  <= csr_wdata[2];
          cfg_rpt <= csr_wdata[6];
          cfg_thr <= csr_wdata[8 +: THR_W];
        end
        OFS_CTL: begin
          ctl_size <= csr_wdata[21:19];
          ctl_dma  <= csr_wdata[14];
          ctl_mono <= csr_wdata[11];
          ctl_play <= csr_wdata[1];
        end
        OFS_FMT: fmt_msbj <= csr_wdata[0];
        OFS_DIV: div_q    <= csr_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst)   underrun_q <= 1'b0;
    else if (urun_set)     underrun_q <= 1'b1;
    else if (wr && csr_addr == OFS_QST && csr_wdata[8]) underrun_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= run && ctl_dma && (level <= LW'({cfg_thr, 1'b0}));
  end

  always_comb begin
    rd_mux = '0;
    case (csr_addr)
      OFS_CFG: begin
        rd_mux[0] = cfg_en; rd_mux[1] = cfg_fm; rd_mux[2] = cfg_bm;
        rd_mux[6] = cfg_rpt; rd_mux[8 +: THR_W] = cfg_thr;
      end
      OFS_CTL: begin
        rd_mux[21:19] = ctl_size; rd_mux[14] = ctl_dma;
        rd_mux[11] = ctl_mono; rd_mux[1] = ctl_play;
      end
      OFS_FMT: rd_mux[0] = fmt_msbj;
      OFS_QST: begin rd_mux[LW-1:0] = level; rd_mux[8] = underrun_q; end
      OFS_PST: rd_mux[2] = busy;
      OFS_DIV: rd_mux[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     csr_rdata <= '0;
    else if (rd) csr_rdata <= rd_mux;
  end

  aud_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SAMPLE_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(soft_rst || flush),
    .push(push), .push_data(csr_wdata[SAMPLE_W-1:0]),
    .pop(q_pop), .head(q_head), .empty(q_empty), .level(level)
  );

  aud_tx_bitclk #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst(rst), .run(run), .master(cfg_bm), .div(div_q),
    .ext_bclk(ext_bclk), .bclk(bclk_int), .fall_evt(fall_evt)
  );

  aud_tx_serial u_ser (
    .clk(clk), .rst(rst), .clr(soft_rst), .run(run), .fall_evt(fall_evt),
    .frame_master(cfg_fm), .ext_ws(ext_ws), .msb_just(fmt_msbj),
    .size_code(ctl_size), .mono(ctl_mono), .repeat_last(cfg_rpt),
    .q_empty(q_empty), .q_head(q_head), .pop(q_pop),
    .underrun_set(urun_set), .sdata(sdata_out), .ws(ser_ws), .busy(busy)
  );

  assign bclk_out = run && cfg_bm && bclk_int;
  assign ws_out   = run && cfg_fm && ser_ws;

  AST_DMA_NEEDS_PLAY: assert property (@(posedge clk) disable iff (rst)
    !run |=> !dma_req); // R4
  AST_SLAVE_BCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !cfg_bm |-> !bclk_out); // R10
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (urun_set && !soft_rst) |=> underrun_q); // R9
endmodule

// File: tb/aud_tx_ctrl_tb.sv
module aud_tx_ctrl_tb;
  logic        clk = 0, rst = 1;
  logic        csr_sel = 0, csr_we = 0;
  logic [5:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        ext_bclk = 1, ext_ws = 1;
  logic        bclk_out, ws_out, sdata_out, dma_req;

  int n_checks = 0, n_fail = 0;
  logic cap [64];
  realtime t_a, t_b;

  always #4 clk = ~clk;

  aud_tx_ctrl u_dut (
    .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ext_bclk(ext_bclk), .ext_ws(ext_ws), .bclk_out(bclk_out),
    .ws_out(ws_out), .sdata_out(sdata_out), .dma_req(dma_req)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); csr_sel = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_sel = 0; csr_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); csr_sel = 1; csr_we = 0; csr_addr = a;
    @(negedge clk); csr_sel = 0; d = csr_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stop_all();
    wr(6'h04, 0); wr(6'h00, 0); wr(6'h04, 32'h100); idle(4);
  endtask

  task automatic capture_master();
    @(negedge ws_out);
    for (int i = 0; i < 64; i++) begin
      @(posedge bclk_out);
      if (i == 0) t_a = $realtime;
      if (i == 1) t_b = $realtime;
      cap[i] = sdata_out;
    end
  endtask

  function automatic logic [23:0] grab(input int off, input int n);
    logic [23:0] v = 0;
    for (int i = 0; i < n; i++) v = {v[22:0], cap[off+i]};
    return v;
  endfunction

  function automatic int ones(input int lo, input int hi);
    int c = 0;
    for (int i = lo; i <= hi; i++) c += int'(cap[i]);
    return c;
  endfunction

  // R1, R12: reset values
  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, d); check(d == 0, "R1 cfg reset", d, 0);
    rd(6'h04, d); check(d == 0, "R1 ctl reset", d, 0);
    rd(6'h14, d); check(d == 0, "R1 qstat reset", d, 0);
    rd(6'h1C, d); check(d == 0, "R1 pstat reset", d, 0);
    check({dma_req, bclk_out, ws_out, sdata_out} == 0, "R12 idle outputs",
          {dma_req, bclk_out, ws_out, sdata_out}, 0);
  endtask

  // R1, R3: field readback, reserved bits, self-clearing bits
  task automatic t_regs();
    logic [31:0] d;
    wr(6'h00, 32'h0000_0546); rd(6'h00, d);
    check(d == 32'h546, "R1 cfg readback", d, 32'h546);
    wr(6'h30, 32'hFFFF_FFFF); rd(6'h30, d);
    check(d == 32'hF, "R1 div readback", d, 32'hF);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, d);
    check(d == 32'h0038_4802, "R3 ctl readback flush reads 0", d, 32'h0038_4802);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, d);
    check(d == 1, "R1 fmt readback", d, 1);
    wr(6'h00, 32'h8); rd(6'h00, d);
    check(d == 0, "R3 soft reset bit reads 0", d, 0);
    wr(6'h04, 0); wr(6'h10, 0); wr(6'h30, 1);
  endtask

  // R2, R3: occupancy, full drop, flush and soft reset
  task automatic t_fifo();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) wr(6'h34, i);
    rd(6'h14, d); check(d[5:0] == 5, "R2 level 5", d[5:0], 5);
    for (int i = 0; i < 30; i++) wr(6'h34, i);
    rd(6'h14, d); check(d[5:0] == 32, "R2 full drops", d[5:0], 32);
    wr(6'h04, 32'h100); rd(6'h14, d);
    check(d[5:0] == 0, "R3 flush empties", d[5:0], 0);
    for (int i = 0; i < 3; i++) wr(6'h34, i);
    wr(6'h00, 32'h8); rd(6'h14, d);
    check(d[5:0] == 0, "R3 soft reset empties", d[5:0], 0);
  endtask

  // R4, R11: DMA request threshold with external clocks held still
  task automatic t_dma();
    logic [31:0] d;
    wr(6'h00, 32'h0000_0201);
    wr(6'h04, 32'h0000_4002);
    for (int i = 0; i < 4; i++) wr(6'h34, i);
    idle(2); check(dma_req == 1, "R4 req at 2T", dma_req, 1);
    wr(6'h34, 9); idle(2);
    check(dma_req == 0, "R4 no req above 2T", dma_req, 0);
    wr(6'h04, 32'h0000_4000); wr(6'h04, 32'h100); idle(2);
    check(dma_req == 0, "R4 no req without play", dma_req, 0);
    rd(6'h1C, d); check(d[2] == 0, "R11 not busy without clocks", d[2], 0);
    stop_all();
  endtask

  // R5, R6, R7, R11, R12: I2S 16-bit stereo as master
  task automatic t_i2s16();
    logic [31:0] d;
    wr(6'h10, 0); wr(6'h30, 1);
    wr(6'h34, 32'hA5C3); wr(6'h34, 32'h1234);
    for (int i = 0; i < 6; i++) wr(6'h34, 32'h7777);
    wr(6'h00, 32'h7); wr(6'h04, 32'h0008_0002);
    capture_master();
    check(grab(1, 16) == 24'hA5C3, "R6 I2S left", grab(1, 16), 24'hA5C3);
    check(grab(33, 16) == 24'h1234, "R6 I2S right", grab(33, 16), 24'h1234);
    check(cap[0] == 0 && ones(17, 32) == 0, "R6 I2S delay and padding", ones(17, 32), 0);
    check(t_b - t_a == 32.0, "R5 bit period", longint'(t_b - t_a), 32);
    rd(6'h1C, d); check(d[2] == 1, "R11 busy while running", d[2], 1);
    wr(6'h04, 0); idle(3);
    check({bclk_out, ws_out, sdata_out} == 0, "R12 outputs after stop",
          {bclk_out, ws_out, sdata_out}, 0);
    rd(6'h1C, d); check(d[2] == 0, "R11 idle after stop", d[2], 0);
    stop_all();
  endtask

  // R6, R7: MSB-justified 24-bit, 20-bit, reserved code
  task automatic t_msbj(input logic [2:0] code, input int n, input logic [23:0] l,
                        input logic [23:0] r, input string tag);
    wr(6'h10, 1); wr(6'h34, l); wr(6'h34, r);
    for (int i = 0; i < 6; i++) wr(6'h34, 0);
    wr(6'h00, 32'h7); wr(6'h04, ({29'b0, code} << 19) | 32'h2);
    capture_master();
    check(grab(0, n) == l, {tag, " left"}, grab(0, n), l);
    check(grab(32, n) == r, {tag, " right"}, grab(32, n), r);
    check(ones(n, 31) == 0, {tag, " padding"}, ones(n, 31), 0);
    stop_all();
  endtask

  // R8: mono 8-bit, one word per frame
  task automatic t_mono();
    wr(6'h10, 0); wr(6'h34, 32'h5A); wr(6'h34, 32'hC3);
    for (int i = 0; i < 4; i++) wr(6'h34, 0);
    wr(6'h00, 32'h7); wr(6'h04, 32'h0000_0802);
    capture_master();
    check(grab(1, 8) == 8'h5A && grab(33, 8) == 8'h5A, "R8 mono frame1", grab(33, 8), 8'h5A);
    capture_master();
    check(grab(1, 8) == 8'hC3 && grab(33, 8) == 8'hC3, "R8 mono frame2", grab(1, 8), 8'hC3);
    stop_all();
  endtask

  // R9: underrun with zeros, flag clear, repeat-last
  task automatic t_underrun();
    logic [31:0] d;
    wr(6'h10, 0); wr(6'h14, 32'h100);
    wr(6'h34, 32'h1111); wr(6'h34, 32'h2222);
    wr(6'h00, 32'h7); wr(6'h04, 32'h0008_0002);
    capture_master(); capture_master();
    check(grab(1, 16) == 0 && grab(33, 16) == 0, "R9 zeros on underrun", grab(1, 16), 0);
    rd(6'h14, d); check(d[8] == 1, "R9 flag set", d[8], 1);
    stop_all();
    wr(6'h14, 32'h100); rd(6'h14, d);
    check(d[8] == 0, "R9 flag cleared", d[8], 0);
    wr(6'h34, 32'h1111); wr(6'h34, 32'h2222);
    wr(6'h00, 32'h47); wr(6'h04, 32'h0008_0002);
    capture_master(); capture_master();
    check(grab(1, 16) == 24'h2222 && grab(33, 16) == 24'h2222, "R9 repeat last",
          grab(1, 16), 24'h2222);
    stop_all();
  endtask

  // R10: both clocks external
  task automatic t_slave();
    wr(6'h10, 0); wr(6'h34, 32'h0F0F); wr(6'h34, 32'hF0F0);
    for (int i = 0; i < 4; i++) wr(6'h34, 0);
    wr(6'h00, 32'h1); wr(6'h04, 32'h0008_0002);
    idle(4);
    for (int i = 0; i < 64; i++) begin
      ext_bclk = 0; ext_ws = (i >= 32);
      #40; cap[i] = sdata_out;
      if (i == 10) check(bclk_out == 0 && ws_out == 0, "R10 outputs low as slave",
                         {bclk_out, ws_out}, 0);
      ext_bclk = 1; #40;
    end
    check(grab(1, 16) == 24'h0F0F, "R10 slave left", grab(1, 16), 24'h0F0F);
    check(grab(33, 16) == 24'hF0F0, "R10 slave right", grab(33, 16), 24'hF0F0);
    ext_ws = 1;
    stop_all();
  endtask

  bit done = 0;
  initial begin
    #(8 * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0; idle(2);
    t_reset();
    t_regs();
    t_fifo();
    t_dma();
    t_i2s16();
    t_msbj(3'd4, 24, 24'hABCDEF, 24'h123456, "R7 24-bit");
    t_msbj(3'd3, 20, 24'hFEDCB, 24'h00001, "R7 20-bit");
    t_msbj(3'd7, 16, 24'h8001, 24'h7FFE, "R7 reserved as 16");
    t_mono();
    t_underrun();
    t_slave();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule